// File: doc/BRIEF.md
# AXI Outstanding Transaction Limiter

This block sits on an AXI link between a manager and a subordinate and caps how many transactions may be open at once. It keeps two counters. One counts reads, from the accepted read address until the read data beat marked last. The other counts writes, from the accepted write address until the write response handshake.

Three limit inputs are compared against these counters every cycle. One limits reads, one limits writes and one limits the sum of both. A limit of zero means that limit is switched off. While any active limit is reached, the block holds the relevant address channel closed in both directions. The downstream valid is forced low and the upstream ready is forced low, so no handshake can happen on either side. The write data, read data and write response channels pass straight through without change.

The limits are plain input ports and may change at run time. A limit lowered below the current count simply keeps the channel closed until enough transactions have completed.

Top module: `axi_pending_limiter`

## Requirements
- R1: After reset both counters are zero, so with every limit at 1 or above a read address and a write address each pass on their own. A reset asserted while transactions are open clears the counts.
- R2: With a non-zero read limit N, once N reads are open a read address is stalled: `m_arvalid` and `s_arready` are both low while `s_arvalid` is high.
- R3: With a non-zero write limit N, once N writes are open a write address is stalled: `m_awvalid` and `s_awready` are both low.
- R4: With a non-zero joint limit N, once open reads plus open writes reach N, both address channels are stalled. Below N, each address channel passes on its own.
- R5: A limit value of 0 imposes no limit from that input.
- R6: A read closes only when a read data beat with `m_rlast` = 1 is accepted (`m_rvalid` and `s_rready` both high). A beat with `m_rlast` = 0 does not free a slot.
- R7: A write closes only on a response handshake (`m_bvalid` and `s_bready` both high). A response that is shown but not accepted does not free a slot.
- R8: An address acceptance and a completion on the same channel in the same cycle leave that counter unchanged.
- R9: When both address channels have `s_*valid` high and each would pass on its own, but the joint limit has room for only one more, the read passes and the write is stalled.
- R10: The write data, read data and write response channels pass through combinationally: payload, valid and ready are copied unchanged in their direction.
- R11: Each counter is CNT_W+1 bits wide, which is 7 bits by default. A counter at its all-ones value (127) stalls its address channel even when every limit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_rd | input | CNT_W | Limit on open reads, 0 = no limit |
| lim_wr | input | CNT_W | Limit on open writes, 0 = no limit |
| lim_sum | input | CNT_W | Limit on open reads plus writes, 0 = no limit |
| s_arvalid | input | 1 | Read address valid from manager |
| s_arready | output | 1 | Read address ready to manager |
| s_ar | input | A_W | Read address payload from manager |
| m_arvalid | output | 1 | Read address valid to subordinate |
| m_arready | input | 1 | Read address ready from subordinate |
| m_ar | output | A_W | Read address payload to subordinate |
| s_awvalid | input | 1 | Write address valid from manager |
| s_awready | output | 1 | Write address ready to manager |
| s_aw | input | A_W | Write address payload from manager |
| m_awvalid | output | 1 | Write address valid to subordinate |
| m_awready | input | 1 | Write address ready from subordinate |
| m_aw | output | A_W | Write address payload to subordinate |
| s_wvalid | input | 1 | Write data valid from manager |
| s_wready | output | 1 | Write data ready to manager |
| s_w | input | W_W | Write data payload from manager |
| m_wvalid | output | 1 | Write data valid to subordinate |
| m_wready | input | 1 | Write data ready from subordinate |
| m_w | output | W_W | Write data payload to subordinate |
| m_rvalid | input | 1 | Read data valid from subordinate |
| m_rready | output | 1 | Read data ready to subordinate |
| m_r | input | R_W | Read data payload from subordinate |
| m_rlast | input | 1 | Last read beat flag from subordinate |
| s_rvalid | output | 1 | Read data valid to manager |
| s_rready | input | 1 | Read data ready from manager |
| s_r | output | R_W | Read data payload to manager |
| s_rlast | output | 1 | Last read beat flag to manager |
| m_bvalid | input | 1 | Write response valid from subordinate |
| m_bready | output | 1 | Write response ready to subordinate |
| m_b | input | B_W | Write response payload from subordinate |
| s_bvalid | output | 1 | Write response valid to manager |
| s_bready | input | 1 | Write response ready from manager |
| s_b | output | B_W | Write response payload to manager |

## Verification
Stall decisions and pass-through signals are combinational on the inputs and the registered counts, so they are due in the same cycle as the stimulus. The effect of a handshake or a completion on the counts appears only after the next rising edge. The bench drives every input just after a falling edge and samples 1 ns later. A probe of an address channel therefore raises valid, samples and withdraws valid before any rising edge, so a probe never creates a transaction of its own. Each handshake takes exactly one rising edge, and its effect on stalling is checked at the next falling edge, one cycle after the stimulus.

// File: rtl/axi_pending_limiter.sv
module axi_pending_limiter #(
  parameter int CNT_W = 6,
  parameter int A_W   = 32,
  parameter int W_W   = 72,
  parameter int R_W   = 70,
  parameter int B_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lim_rd,
  input  logic [CNT_W-1:0] lim_wr,
  input  logic [CNT_W-1:0] lim_sum,
  input  logic             s_arvalid,
  output logic             s_arready,
  input  logic [A_W-1:0]   s_ar,
  output logic             m_arvalid,
  input  logic             m_arready,
  output logic [A_W-1:0]   m_ar,
  input  logic             s_awvalid,
  output logic             s_awready,
  input  logic [A_W-1:0]   s_aw,
  output logic             m_awvalid,
  input  logic             m_awready,
  output logic [A_W-1:0]   m_aw,
  input  logic             s_wvalid,
  output logic             s_wready,
  input  logic [W_W-1:0]   s_w,
  output logic             m_wvalid,
  input  logic             m_wready,
  output logic [W_W-1:0]   m_w,
  input  logic             m_rvalid,
  output logic             m_rready,
  input  logic [R_W-1:0]   m_r,
  input  logic             m_rlast,
  output logic             s_rvalid,
  input  logic             s_rready,
  output logic [R_W-1:0]   s_r,
  output logic             s_rlast,
  input  logic             m_bvalid,
  output logic             m_bready,
  input  logic [B_W-1:0]   m_b,
  output logic             s_bvalid,
  input  logic             s_bready,
  output logic [B_W-1:0]   s_b
);

  localparam int CW = CNT_W + 1;
  localparam int SW = CW + 1;
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] rd_cnt, wr_cnt;
  logic [SW-1:0] sum_cnt, lim_sum_x;
  logic rd_room, wr_room, sum_room1, sum_room2;
  logic ar_go, aw_go;
  logic ar_hs, aw_hs, r_done, b_done;

  assign sum_cnt   = SW'(rd_cnt) + SW'(wr_cnt);
  assign lim_sum_x = SW'(lim_sum);

  assign rd_room   = (rd_cnt != FULL) && (lim_rd == '0 || rd_cnt < CW'(lim_rd));
  assign wr_room   = (wr_cnt != FULL) && (lim_wr == '0 || wr_cnt < CW'(lim_wr));
  assign sum_room1 = (lim_sum == '0) || (sum_cnt < lim_sum_x);
  assign sum_room2 = (lim_sum == '0) || (sum_cnt + SW'(1) < lim_sum_x);

  assign ar_go = rd_room && sum_room1;
  assign aw_go = wr_room && sum_room1 && !(s_arvalid && ar_go && !sum_room2);

  assign m_arvalid = s_arvalid & ar_go;
  assign s_arready = m_arready & ar_go;
  assign m_ar      = s_ar;
  assign m_awvalid = s_awvalid & aw_go;
  assign s_awready = m_awready & aw_go;
  assign m_aw      = s_aw;

  assign m_wvalid = s_wvalid;
  assign s_wready = m_wready;
  assign m_w      = s_w;
  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;
  assign s_r      = m_r;
  assign s_rlast  = m_rlast;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_b      = m_b;

  assign ar_hs  = s_arvalid & s_arready;
  assign aw_hs  = s_awvalid & s_awready;
  assign r_done = m_rvalid & s_rready & m_rlast;
  assign b_done = m_bvalid & s_bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      case ({ar_hs, r_done})
        2'b10:   rd_cnt <= rd_cnt + CW'(1);
        2'b01:   rd_cnt <= rd_cnt - CW'(1);
        default: rd_cnt <= rd_cnt;
      endcase
      case ({aw_hs, b_done})
        2'b10:   wr_cnt <= wr_cnt + CW'(1);
        2'b01:   wr_cnt <= wr_cnt - CW'(1);
        default: wr_cnt <= wr_cnt;
      endcase
    end
  end

  p_rd_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_rd != '0 && rd_cnt >= CW'(lim_rd)) |-> (!m_arvalid && !s_arready));

  p_no_leak_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid |-> s_arvalid) and (s_arready |-> m_arready) and
    (m_awvalid |-> s_awvalid) and (s_awready |-> m_awready));

  p_wr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr != '0 && wr_cnt >= CW'(lim_wr)) |-> (!m_awvalid && !s_awready));

  p_sum_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_sum != '0 && sum_cnt >= lim_sum_x) |-> (!m_arvalid && !m_awvalid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_hs && r_done) |=> $stable(rd_cnt));

  p_read_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && m_awvalid) |-> (lim_sum == '0 || sum_cnt + SW'(2) <= lim_sum_x));

  p_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == FULL) |-> !m_arvalid);

endmodule

// File: tb/tb_axi_pending_limiter.sv
module tb_axi_pending_limiter;
  localparam int CNT_W = 6, A_W = 32, W_W = 72, R_W = 70, B_W = 6;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] lim_rd = 0, lim_wr = 0, lim_sum = 0;
  logic s_arvalid = 0, s_arready, m_arvalid, m_arready = 0;
  logic s_awvalid = 0, s_awready, m_awvalid, m_awready = 0;
  logic [A_W-1:0] s_ar = 32'h1000, m_ar, s_aw = 32'h2000, m_aw;
  logic s_wvalid = 0, s_wready, m_wvalid, m_wready = 0;
  logic [W_W-1:0] s_w = 0, m_w;
  logic m_rvalid = 0, m_rready, s_rvalid, s_rready = 0, m_rlast = 0, s_rlast;
  logic [R_W-1:0] m_r = 0, s_r;
  logic m_bvalid = 0, m_bready, s_bvalid, s_bready = 0;
  logic [B_W-1:0] m_b = 0, s_b;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  axi_pending_limiter #(.CNT_W(CNT_W), .A_W(A_W), .W_W(W_W), .R_W(R_W), .B_W(B_W)) dut (
    .clk(clk), .rst_n(rst_n), .lim_rd(lim_rd), .lim_wr(lim_wr), .lim_sum(lim_sum),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_ar(s_ar),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_ar(m_ar),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_aw(s_aw),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_aw(m_aw),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_w(s_w),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_w(m_w),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_r(m_r), .m_rlast(m_rlast),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_r(s_r), .s_rlast(s_rlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_b(m_b),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_b(s_b));

  typedef struct packed {
    logic [7:0] req;
    logic [CNT_W-1:0] lr, lw, ls;
    logic [7:0] nr, nw;
    logic ar_open, aw_open;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 6'd2, 6'd0, 6'd0, 8'd2,  8'd0,  1'b0, 1'b1},
    '{8'd2, 6'd2, 6'd0, 6'd0, 8'd1,  8'd0,  1'b1, 1'b1},
    '{8'd3, 6'd0, 6'd3, 6'd0, 8'd0,  8'd3,  1'b1, 1'b0},
    '{8'd4, 6'd0, 6'd0, 6'd4, 8'd2,  8'd2,  1'b0, 1'b0},
    '{8'd4, 6'd0, 6'd0, 6'd4, 8'd3,  8'd0,  1'b1, 1'b1},
    '{8'd5, 6'd0, 6'd0, 6'd0, 8'd10, 8'd10, 1'b1, 1'b1},
    '{8'd2, 6'd8, 6'd0, 6'd0, 8'd8,  8'd0,  1'b0, 1'b1},
    '{8'd4, 6'd5, 6'd5, 6'd6, 8'd3,  8'd3,  1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start just after a falling edge and end at the next one.
  task automatic issue_rd();
    s_arvalid = 1; m_arready = 1;
    @(negedge clk); s_arvalid = 0; m_arready = 0;
  endtask

  task automatic issue_wr();
    s_awvalid = 1; m_awready = 1;
    @(negedge clk); s_awvalid = 0; m_awready = 0;
  endtask

  task automatic rd_beat(input logic last);
    m_rvalid = 1; m_rlast = last; s_rready = 1;
    @(negedge clk); m_rvalid = 0; m_rlast = 0; s_rready = 0;
  endtask

  task automatic b_resp();
    m_bvalid = 1; s_bready = 1;
    @(negedge clk); m_bvalid = 0; s_bready = 0;
  endtask

  task automatic probe_ar(input string req, input logic exp_open);
    s_arvalid = 1; m_arready = 1; #1;
    check(req, {m_arvalid, s_arready}, {exp_open, exp_open});
    s_arvalid = 0; m_arready = 0; #1;
  endtask

  task automatic probe_aw(input string req, input logic exp_open);
    s_awvalid = 1; m_awready = 1; #1;
    check(req, {m_awvalid, s_awready}, {exp_open, exp_open});
    s_awvalid = 0; m_awready = 0; #1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, then each channel passes with limits of 1
    #1 check("R1 idle", {m_arvalid, m_awvalid}, 2'b00);
    lim_rd = 1; lim_wr = 1; lim_sum = 2;
    probe_ar("R1 ar after reset", 1'b1);
    probe_aw("R1 aw after reset", 1'b1);
    @(negedge clk);
    issue_rd(); issue_wr();
    probe_ar("R1 ar full before reset", 1'b0);
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    probe_ar("R1 ar after mid reset", 1'b1);
    probe_aw("R1 aw after mid reset", 1'b1);
    @(negedge clk);

    // Table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      lim_rd = VEC[i].lr; lim_wr = VEC[i].lw; lim_sum = VEC[i].ls;
      for (int k = 0; k < int'(VEC[i].nr); k++) issue_rd();
      for (int k = 0; k < int'(VEC[i].nw); k++) issue_wr();
      probe_ar($sformatf("R%0d row %0d ar", VEC[i].req, i), VEC[i].ar_open);
      probe_aw($sformatf("R%0d row %0d aw", VEC[i].req, i), VEC[i].aw_open);
      @(negedge clk);
      for (int k = 0; k < int'(VEC[i].nr); k++) rd_beat(1'b1);
      for (int k = 0; k < int'(VEC[i].nw); k++) b_resp();
      probe_ar($sformatf("R%0d row %0d ar drained", VEC[i].req, i), 1'b1);
      probe_aw($sformatf("R%0d row %0d aw drained", VEC[i].req, i), 1'b1);
      @(negedge clk);
    end

    // R6: only the last beat releases a read
    lim_rd = 1; lim_wr = 0; lim_sum = 0;
    issue_rd();
    rd_beat(1'b0);
    probe_ar("R6 after non-last beat", 1'b0);
    @(negedge clk);
    rd_beat(1'b1);
    probe_ar("R6 after last beat", 1'b1);
    @(negedge clk);

    // R7: only a completed response releases a write
    lim_rd = 0; lim_wr = 1;
    issue_wr();
    m_bvalid = 1; s_bready = 0;
    @(negedge clk);
    probe_aw("R7 response not accepted", 1'b0);
    m_bvalid = 0;
    @(negedge clk);
    b_resp();
    probe_aw("R7 response accepted", 1'b1);
    @(negedge clk);

    // R8: accept and complete in one cycle leaves the count at 1
    lim_rd = 2; lim_wr = 0;
    issue_rd();
    s_arvalid = 1; m_arready = 1; m_rvalid = 1; m_rlast = 1; s_rready = 1;
    @(negedge clk);
    s_arvalid = 0; m_arready = 0; m_rvalid = 0; m_rlast = 0; s_rready = 0;
    probe_ar("R8 one open after overlap", 1'b1);
    issue_rd();
    probe_ar("R8 two open", 1'b0);
    @(negedge clk);
    rd_beat(1'b1); rd_beat(1'b1);

    // R9: joint limit room for one, read wins
    lim_rd = 0; lim_wr = 0; lim_sum = 3;
    issue_rd(); issue_rd();
    s_arvalid = 1; m_arready = 1; s_awvalid = 1; m_awready = 1; #1;
    check("R9 read passes", {m_arvalid, s_arready}, 2'b11);
    check("R9 write held", {m_awvalid, s_awready}, 2'b00);
    s_arvalid = 0; m_arready = 0; s_awvalid = 0; m_awready = 0; #1;
    probe_aw("R9 write alone passes", 1'b1);
    @(negedge clk);
    rd_beat(1'b1); rd_beat(1'b1);
    lim_sum = 0;

    // R10: data channels pass through
    s_w = 72'hA5_1234_5678_9ABC_DEF0; s_wvalid = 1; m_wready = 0;
    m_r = 70'h2A_CAFE_F00D_BEEF_0001; m_rvalid = 1; s_rready = 0; m_rlast = 0;
    m_b = 6'h2D; m_bvalid = 1; s_bready = 1; #1;
    check("R10 w", {m_w, m_wvalid, s_wready}, {s_w, 1'b1, 1'b0});
    check("R10 r", {s_r, s_rvalid, m_rready, s_rlast}, {m_r, 1'b1, 1'b0, 1'b0});
    check("R10 b", {s_b, s_bvalid, m_bready}, {m_b, 1'b1, 1'b1});
    s_wvalid = 0; m_rvalid = 0; m_bvalid = 0; s_bready = 0; #1;
    @(negedge clk);

    // R11: counter saturates at 127 with all limits off
    for (int k = 0; k < 126; k++) issue_rd();
    probe_ar("R11 at 126 open", 1'b1);
    issue_rd();
    probe_ar("R11 at 127 stalled", 1'b0);
    @(negedge clk);
    rd_beat(1'b1);
    probe_ar("R11 at 126 again", 1'b1);
    @(negedge clk);
    for (int k = 0; k < 126; k++) rd_beat(1'b1);
    probe_ar("R11 drained", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule